// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a 7-bit down counter that must be reloaded inside a time window. The counter steps down once per watchdog tick. A tick is produced from the peripheral clock by a fixed base divider (4096 by default), followed by a selectable stage of 1, 2, 4 or 8. Software arms the watchdog and reloads the counter through a control write. It sets the upper window limit and the prescaler through a configuration write.

Three situations raise a system reset:
- The counter steps from 0x40 to 0x3F, which is a timeout.
- Software reloads while the count is still above the window limit, which is an early refresh.
- Software loads a value whose bit 6 is clear while the watchdog is armed or being armed.

The reset leaves as a pulse of fixed length. During the pulse the watchdog returns its own state to the reset values. A sticky flag records that the watchdog caused a reset, and it stays set until software clears it.

With the base divider at 4096 and a 42 MHz clock, one tick lasts about 97.5 µs. The longest timeout is about 49.9 ms: 64 ticks with the prescaler at 8. The current count and the armed state can be read back on their own outputs.

Top module: `wwdt_top`

## Requirements
- R1: After rst_n the reset output is low, the flag is low, the watchdog is disarmed, the count reads 0x7F, the window limit is 0x7F and the prescaler select is 0.
- R2: While the watchdog is armed, the count decreases by one every BASE_DIV*2^sel clock cycles, where psc_sel 0, 1, 2 and 3 select 1, 2, 4 and 8. The first step comes that many cycles after the last counter write, because every accepted write restarts the tick timing. While the watchdog is disarmed the count holds.
- R3: After an armed load of value V (V ≥ 0x41) with no further writes, wdg_rst_o rises exactly (V-63)*BASE_DIV*2^sel cycles after the loading edge. That is the edge at which the count would step from 0x40 to 0x3F.
- R4: A counter write while armed and with the current count strictly greater than the window limit raises wdg_rst_o at that write's edge. A count of window+1 counts as too early.
- R5: A counter write while armed, with the count at or below the window limit and bit 6 of the new value set, reloads the count and does not raise a reset.
- R6: A counter write with bit 6 (value 0x40) of the new value clear raises a reset at once if the watchdog is armed or ctl_arm is 1. If neither holds, the value loads without a reset.
- R7: Once armed, the watchdog cannot be disarmed by any write. A control write with ctl_arm = 0 leaves it armed. Only a watchdog reset or rst_n disarms it.
- R8: wdg_rst_o stays high for exactly PULSE_LEN cycles. The watchdog is disarmed while the pulse is high, and writes during the pulse are ignored. After the pulse, the count, the window limit, the prescaler select and the armed state hold their R1 values.
- R9: wdg_flag_o is set by every watchdog reset. It keeps its value until flag_clr is pulsed or rst_n is applied, and a reset in the same cycle as flag_clr wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low power-on reset, also clears the flag |
| ctl_we | input | 1 | Control write strobe (counter load / refresh) |
| ctl_arm | input | 1 | Arm bit carried with a control write |
| ctl_count | input | 7 | Counter value carried with a control write |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_window | input | 7 | Window upper limit |
| cfg_psc | input | 2 | Prescaler select: 0..3 give 1, 2, 4, 8 |
| flag_clr | input | 1 | Clears the sticky reset flag |
| wdg_rst_o | output | 1 | System reset pulse |
| wdg_flag_o | output | 1 | Sticky watchdog-reset flag |
| wdg_count_o | output | 7 | Current counter value |
| wdg_armed_o | output | 1 | Watchdog armed |

## Verification
The bound checker tests these rules on every cycle:
- Bit 6 of the count is never clear while the watchdog is armed.
- An early write or a 0x40 tick is followed by the reset pulse.
- The armed state never drops without a fault.
- The pulse lasts exactly PULSE_LEN cycles and keeps the watchdog disarmed.
- The flag rises with the pulse and holds until it is cleared.

Only the bench's scenarios can show the rest:
- The absolute timeout cycle for each prescaler setting.
- The restart of tick timing on a refresh.
- The exact window boundary, where a write at the limit passes and one count above it fails.
- That writes during the pulse are lost.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int CNT_W = 7;
  localparam int SEL_W = 2;
  localparam logic [CNT_W-1:0] CNT_INIT = 7'h7F;
  localparam logic [CNT_W-1:0] CNT_LAST_OK = 7'h40;
  localparam logic [CNT_W-1:0] WIN_INIT = 7'h7F;

  // last index of the secondary divide stage (0, 1, 3 or 7)
  function automatic logic [2:0] stage_last(input logic [SEL_W-1:0] sel);
    logic [3:0] span;
    span = 4'd1 << sel;
    return 3'(span - 4'd1);
  endfunction

  // refresh is too early while the count sits above the window limit
  function automatic logic too_early(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] win);
    return cnt > win;
  endfunction

  // a step from this value clears the top bit
  function automatic logic at_expiry(input logic [CNT_W-1:0] cnt);
    return cnt == CNT_LAST_OK;
  endfunction

  // a loaded value without the top bit would already be expired
  function automatic logic bad_value(input logic [CNT_W-1:0] v);
    return !v[CNT_W-1];
  endfunction
endpackage

// File: rtl/wwdt_prescaler.sv
module wwdt_prescaler
  import wwdt_pkg::*;
#(
  parameter int BASE_DIV = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o
);
  localparam int DIV_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BASE_DIV - 1);

  logic       base_tick;
  logic [2:0] stage_q;
  logic [2:0] stage_end;

  generate
    if (BASE_DIV > 1) begin : g_base
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (!run || restart)  div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign base_tick = run && !restart && (div_q == DIV_LAST);
    end else begin : g_nobase
      assign base_tick = run && !restart;
    end
  endgenerate

  assign stage_end = stage_last(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   stage_q <= '0;
    else if (!run || restart)     stage_q <= '0;
    else if (base_tick) begin
      if (stage_q >= stage_end)   stage_q <= '0;
      else                        stage_q <= stage_q + 3'd1;
    end
  end

  assign tick_o = base_tick && (stage_q >= stage_end);
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
  import wwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             tick,
  input  logic             ctl_we,
  input  logic             ctl_arm,
  input  logic [CNT_W-1:0] ctl_count,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_window,
  input  logic [SEL_W-1:0] cfg_psc,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] win_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             armed_o,
  output logic             restart_o,
  output logic             f_early_o,
  output logic             f_load_o,
  output logic             f_timeout_o
);
  logic [CNT_W-1:0] cnt_q, win_q;
  logic [SEL_W-1:0] sel_q;
  logic             arm_q;
  logic             wr_ok, fault;

  assign wr_ok       = ctl_we && !hold;
  assign f_early_o   = wr_ok && arm_q && too_early(cnt_q, win_q);
  assign f_load_o    = wr_ok && (arm_q || ctl_arm) && bad_value(ctl_count);
  assign f_timeout_o = !hold && !ctl_we && arm_q && tick && at_expiry(cnt_q);
  assign fault       = f_early_o || f_load_o || f_timeout_o;
  assign restart_o   = wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
      win_q <= WIN_INIT;
      sel_q <= '0;
      arm_q <= 1'b0;
    end else if (hold || fault) begin
      cnt_q <= CNT_INIT;
      win_q <= WIN_INIT;
      sel_q <= '0;
      arm_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        win_q <= cfg_window;
        sel_q <= cfg_psc;
      end
      if (ctl_we) begin
        cnt_q <= ctl_count;
        arm_q <= arm_q | ctl_arm;
      end else if (arm_q && tick) begin
        cnt_q <= cnt_q - 7'd1;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign win_o   = win_q;
  assign sel_o   = sel_q;
  assign armed_o = arm_q;
endmodule

// File: rtl/wwdt_reset_gen.sv
module wwdt_reset_gen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault,
  input  logic flag_clr,
  output logic rst_o,
  output logic flag_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);

  logic [PW-1:0] left_q;
  logic          flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fault)          left_q <= PLEN;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (fault)    flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign rst_o  = (left_q != '0);
  assign flag_o = flag_q;
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int BASE_DIV  = 4096,
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic       ctl_arm,
  input  logic [6:0] ctl_count,
  input  logic       cfg_we,
  input  logic [6:0] cfg_window,
  input  logic [1:0] cfg_psc,
  input  logic       flag_clr,
  output logic       wdg_rst_o,
  output logic       wdg_flag_o,
  output logic [6:0] wdg_count_o,
  output logic       wdg_armed_o
);
  logic             tick_w, restart_w, hold_w;
  logic             fault_early_w, fault_load_w, fault_timeout_w, fault_w;
  logic [CNT_W-1:0] win_w;
  logic [SEL_W-1:0] sel_w;

  assign hold_w  = wdg_rst_o;
  assign fault_w = fault_early_w || fault_load_w || fault_timeout_w;

  wwdt_prescaler #(.BASE_DIV(BASE_DIV)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wdg_armed_o),
    .restart(restart_w),
    .sel    (sel_w),
    .tick_o (tick_w)
  );

  wwdt_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold_w),
    .tick       (tick_w),
    .ctl_we     (ctl_we),
    .ctl_arm    (ctl_arm),
    .ctl_count  (ctl_count),
    .cfg_we     (cfg_we),
    .cfg_window (cfg_window),
    .cfg_psc    (cfg_psc),
    .cnt_o      (wdg_count_o),
    .win_o      (win_w),
    .sel_o      (sel_w),
    .armed_o    (wdg_armed_o),
    .restart_o  (restart_w),
    .f_early_o  (fault_early_w),
    .f_load_o   (fault_load_w),
    .f_timeout_o(fault_timeout_w)
  );

  wwdt_reset_gen #(.PULSE_LEN(PULSE_LEN)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault   (fault_w),
    .flag_clr(flag_clr),
    .rst_o   (wdg_rst_o),
    .flag_o  (wdg_flag_o)
  );
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic       flag_clr,
  input logic       rst_o,
  input logic       flag_o,
  input logic       armed,
  input logic [6:0] count,
  input logic [6:0] window,
  input logic       tick,
  input logic       fault
);
  localparam int LW = $clog2(PULSE_LEN + 2);
  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     len_q <= '0;
    else if (rst_o) len_q <= len_q + 1'b1;
    else            len_q <= '0;
  end

  p_top_bit_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> count[6]);

  p_early_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && armed && !rst_o && count > window) |=> rst_o);

  p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && !ctl_we && !rst_o && count == 7'h40) |=> rst_o);

  p_arm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fault) |=> armed);

  p_pulse_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> (len_q < LW'(PULSE_LEN)));

  p_pulse_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> (len_q == LW'(PULSE_LEN)));

  p_pulse_disarmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> !armed);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> flag_o);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr) |=> flag_o);
endmodule

bind wwdt_top wwdt_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctl_we  (ctl_we),
  .flag_clr(flag_clr),
  .rst_o   (wdg_rst_o),
  .flag_o  (wdg_flag_o),
  .armed   (wdg_armed_o),
  .count   (wdg_count_o),
  .window  (win_w),
  .tick    (tick_w),
  .fault   (fault_w)
);

// File: tb/sim_wwdt_top.sv
module sim_wwdt_top;
  localparam int BD = 4;
  localparam int PL = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0, ctl_arm = 1'b0, cfg_we = 1'b0, flag_clr = 1'b0;
  logic [6:0] ctl_count = '0, cfg_window = '0;
  logic [1:0] cfg_psc = '0;
  logic       wdg_rst_o, wdg_flag_o, wdg_armed_o;
  logic [6:0] wdg_count_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wwdt_top #(.BASE_DIV(BD), .PULSE_LEN(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_arm(ctl_arm),
    .ctl_count(ctl_count), .cfg_we(cfg_we), .cfg_window(cfg_window),
    .cfg_psc(cfg_psc), .flag_clr(flag_clr), .wdg_rst_o(wdg_rst_o),
    .wdg_flag_o(wdg_flag_o), .wdg_count_o(wdg_count_o),
    .wdg_armed_o(wdg_armed_o)
  );

  function automatic int period(input int sel);
    return BD * (1 << sel);
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_ctl(input logic [6:0] v, input logic arm);
    @(negedge clk);
    ctl_we = 1'b1; ctl_count = v; ctl_arm = arm;
    @(negedge clk);
    ctl_we = 1'b0; ctl_arm = 1'b0;
  endtask

  task automatic do_cfg(input logic [6:0] w, input logic [1:0] s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_window = w; cfg_psc = s;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle_and_clear();
    repeat (PL + 2) @(posedge clk);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rst_o", wdg_rst_o, 0);
    chk("R1 flag", wdg_flag_o, 0);
    chk("R1 armed", wdg_armed_o, 0);
    chk("R1 count", wdg_count_o, 'h7F);
  endtask

  task automatic t_disarmed_hold();
    do_ctl(7'h70, 1'b0);
    repeat (50) @(posedge clk);
    #1;
    chk("R2 count holds while disarmed", wdg_count_o, 'h70);
    chk("R2 still disarmed", wdg_armed_o, 0);
    do_ctl(7'h3F, 1'b0);
    #1;
    chk("R6 disarmed low load no reset", wdg_rst_o, 0);
    chk("R6 disarmed low load value", wdg_count_o, 'h3F);
    do_ctl(7'h10, 1'b1);
    #1;
    chk("R6 arming low load resets", wdg_rst_o, 1);
    settle_and_clear();
  endtask

  task automatic t_timeout(input logic [6:0] v, input int sel);
    int p, n;
    p = period(sel);
    n = (v - 63) * p;
    do_cfg(7'h7F, 2'(sel));
    do_ctl(v, 1'b1);
    repeat (p - 1) @(posedge clk);
    #1;
    chk("R2 count before first step", wdg_count_o, v);
    @(posedge clk); #1;
    chk("R2 count after first step", wdg_count_o, v - 1);
    repeat (n - p - 1) @(posedge clk);
    #1;
    chk("R3 no reset one cycle early", wdg_rst_o, 0);
    chk("R3 count at 0x40", wdg_count_o, 'h40);
    @(posedge clk); #1;
    chk("R3 reset at timeout", wdg_rst_o, 1);
    chk("R9 flag set", wdg_flag_o, 1);
    chk("R8 disarmed in pulse", wdg_armed_o, 0);
    repeat (PL - 1) @(posedge clk);
    #1;
    chk("R8 pulse still high", wdg_rst_o, 1);
    @(posedge clk); #1;
    chk("R8 pulse ended", wdg_rst_o, 0);
    chk("R8 count back to init", wdg_count_o, 'h7F);
    chk("R9 flag sticky after pulse", wdg_flag_o, 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R9 flag cleared", wdg_flag_o, 0);
  endtask

  task automatic t_early();
    do_cfg(7'h50, 2'd0);
    do_ctl(7'h7F, 1'b1);
    do_ctl(7'h7F, 1'b1);
    #1;
    chk("R4 early refresh resets", wdg_rst_o, 1);
    settle_and_clear();
    do_cfg(7'h5E, 2'd0);
    do_ctl(7'h60, 1'b1);
    repeat (4) @(posedge clk);
    do_ctl(7'h60, 1'b1);
    #1;
    chk("R4 window+1 is early", wdg_rst_o, 1);
    settle_and_clear();
  endtask

  task automatic t_in_window();
    do_cfg(7'h5E, 2'd0);
    do_ctl(7'h60, 1'b1);
    repeat (8) @(posedge clk);
    #1;
    chk("R2 count reached window", wdg_count_o, 'h5E);
    do_ctl(7'h62, 1'b0);
    #1;
    chk("R5 refresh at limit no reset", wdg_rst_o, 0);
    chk("R5 refresh reloads", wdg_count_o, 'h62);
    chk("R7 arm=0 ignored", wdg_armed_o, 1);
    repeat (3) @(posedge clk);
    #1;
    chk("R2 restart holds count", wdg_count_o, 'h62);
    @(posedge clk); #1;
    chk("R2 step after restart", wdg_count_o, 'h61);
    do_ctl(7'h00, 1'b0);
    #1;
    chk("R6 armed low load resets", wdg_rst_o, 1);
    do_ctl(7'h70, 1'b1);
    repeat (PL + 2) @(posedge clk);
    #1;
    chk("R8 write during pulse ignored armed", wdg_armed_o, 0);
    chk("R8 write during pulse ignored count", wdg_count_o, 'h7F);
    settle_and_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disarmed_hold();
    t_timeout(7'h45, 0);
    t_timeout(7'h41, 3);
    t_early();
    t_in_window();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule